// File: doc/BRIEF.md
# Haptic Waveform Player

This block plays back a stored haptic effect. It reads a stream of two-byte records from a small synchronous waveform RAM and turns them into a sequence of amplitude values for an actuator driver. Each record holds a level byte and then a duration byte. The top bit of the level byte chooses how the record behaves. With the bit clear, the level is held for the duration. With the bit set, the output moves in straight-line steps to the level of the record that follows.

Time advances only on an external tick strobe, which normally comes once every 5 ms. A one-cycle start pulse latches the start address and the byte count, and playback begins. While one segment plays, the player fetches the next record, so a new segment takes over on the same tick that ends the old one. A mode input selects how the 7-bit level is read: either as an unsigned magnitude or as a signed value for bidirectional drive.

Top module: `haptic_wave_player`

## Requirements
- R1: Records are read from consecutive RAM addresses, starting at the start address. Byte 0 of a record is the level byte and byte 1 is the duration in ticks. Bit 7 of the level byte is the ramp flag, and bits 6:0 are the level code.
- R2: With `bidir_i` low, the level code is unsigned (0 to 127) and is driven zero-extended on `amp_o`. With `bidir_i` high, the code is 7-bit two's complement and is driven sign-extended. The code for -64 is driven as -63.
- R3: A record with the ramp flag clear and duration T>0 drives its level for T tick intervals. Playback then moves to the next record.
- R4: A ramp record with level a, duration T>0 and next-record level b drives a + s*floor(|b-a|*j/T) in interval j, for j=0..T-1, where s is the sign of b-a. On the tick that ends the ramp, the output takes the following record's level. Each tick must come at least 140 clock cycles after the previous one.
- R5: The record after a ramp follows its own ramp flag, so ramps can be chained back to back.
- R6: A ramp record that is the last record of the stream is played as a hold at its own level.
- R7: A record with a duration of zero adds no tick intervals. Playback goes straight to the next record.
- R8: Once the last record ends, `amp_o` returns to 0, `busy_o` and `amp_valid_o` fall, and `done_o` pulses for exactly one cycle. A trailing odd byte within the length is never played. A length below 2 finishes without driving any level.
- R9: A start pulse while `busy_o` is high is ignored. Playback and RAM reads go on unchanged.
- R10: During and after reset, `amp_o` is 0 and `busy_o`, `amp_valid_o`, `done_o` and `ram_rd_en_o` are low.
- R11: RAM reads have one cycle of latency. The player never reads an address outside start address to start address + 2*floor(length/2) - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start request |
| start_addr_i | input | 8 | RAM address of the first record |
| length_i | input | 9 | Stream length in bytes |
| bidir_i | input | 1 | 1: signed levels, 0: unsigned levels |
| tick_i | input | 1 | Periodic time-step strobe |
| ram_rd_en_o | output | 1 | RAM read enable |
| ram_addr_o | output | 8 | RAM read address |
| ram_data_i | input | 8 | RAM read data, valid one cycle after the read |
| amp_o | output | 8 | Amplitude, two's complement |
| amp_valid_o | output | 1 | A segment is playing |
| busy_o | output | 1 | Playback in progress |
| done_o | output | 1 | One-cycle pulse when playback ends |

## Verification
The hardest case to reach from the ports is a record boundary where the segment after the current one is not an ordinary hold. Examples are a ramp whose end level comes from a record that has not been fetched yet, a zero-duration record that comes right after a ramp, and a ramp that turns out to be the last record. The bench reaches these through the RAM contents it loads. It places zero-length records, back-to-back ramps and a trailing ramp followed by an odd stray byte in short streams, and then steps ticks one at a time. A second start pulse sent partway through a run checks that neither the outputs nor the read addresses change.

// File: rtl/hwp_pkg.sv
package hwp_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_VOLT = 2'd1,
    FS_TIME = 2'd2
  } fetch_state_t;

  typedef enum logic [1:0] {
    SG_EMPTY = 2'd0,
    SG_SETUP = 2'd1,
    SG_RUN   = 2'd2
  } seg_state_t;

  localparam int LVL_W = 9;
  typedef logic signed [LVL_W-1:0] level_t;

  // Map a 7-bit level code to a signed working level.
  function automatic level_t decode_level(input logic [6:0] code, input logic bidir);
    level_t res;
    if (!bidir)
      res = level_t'({2'b00, code});
    else if (code == 7'h40)
      res = level_t'(-63);
    else
      res = level_t'({{2{code[6]}}, code});
    return res;
  endfunction

endpackage

// File: rtl/hwp_fetch.sv
module hwp_fetch
  import hwp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              take_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              rec_vld_o,
  output logic [7:0]        rec_volt_o,
  output logic [7:0]        rec_time_o,
  output logic              drained_o
);

  localparam logic [LEN_W-1:0] REC_BYTES = LEN_W'(2);

  fetch_state_t      st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [7:0]        vbuf_q, vbuf_d;
  logic [7:0]        volt_q, volt_d;
  logic [7:0]        time_q, time_d;
  logic              vld_q, vld_d;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    left_d  = left_q;
    vbuf_d  = vbuf_q;
    volt_d  = volt_q;
    time_d  = time_q;
    vld_d   = vld_q;
    rd_en_o = 1'b0;
    if (take_i) vld_d = 1'b0;
    if (load_i) begin
      st_d   = FS_IDLE;
      addr_d = base_i;
      left_d = len_i;
      vld_d  = 1'b0;
    end else begin
      unique case (st_q)
        FS_IDLE: begin
          if (!vld_q && left_q >= REC_BYTES) begin
            rd_en_o = 1'b1;
            addr_d  = addr_q + 1'b1;
            left_d  = left_q - REC_BYTES;
            st_d    = FS_VOLT;
          end
        end
        FS_VOLT: begin
          vbuf_d  = rd_data_i;
          rd_en_o = 1'b1;
          addr_d  = addr_q + 1'b1;
          st_d    = FS_TIME;
        end
        FS_TIME: begin
          volt_d = vbuf_q;
          time_d = rd_data_i;
          vld_d  = 1'b1;
          st_d   = FS_IDLE;
        end
        default: st_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
      left_q <= '0;
      vbuf_q <= '0;
      volt_q <= '0;
      time_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      left_q <= left_d;
      vbuf_q <= vbuf_d;
      volt_q <= volt_d;
      time_q <= time_d;
      vld_q  <= vld_d;
    end
  end

  assign rd_addr_o  = addr_q;
  assign rec_vld_o  = vld_q;
  assign rec_volt_o = volt_q;
  assign rec_time_o = time_q;
  assign drained_o  = (st_q == FS_IDLE) && !vld_q && (left_q < REC_BYTES);

  // R1: the player consumes a record only when one is buffered
  p_take_needs_record_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> vld_q) else $error("record taken while buffer empty");

  // R1: a buffered record stays unchanged until it is consumed
  p_record_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !take_i && !load_i) |=> (vld_q && $stable(volt_q) && $stable(time_q)))
    else $error("buffered record lost");

endmodule

// File: rtl/hwp_ramp.sv
module hwp_ramp
  import hwp_pkg::*;
#(
  parameter int SPAN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  level_t            from_i,
  input  level_t            to_i,
  input  logic [SPAN_W-1:0] span_i,
  input  logic              step_i,
  output level_t            level_o,
  output logic              settled_o
);

  localparam int DIFF_W = LVL_W + 1;
  localparam int ERR_W  = SPAN_W + 1;

  logic signed [DIFF_W-1:0] diff;
  logic [SPAN_W-1:0]        diff_mag;

  level_t            base_q, base_d;
  logic [SPAN_W-1:0] mag_q, mag_d;
  logic              neg_q, neg_d;
  logic [SPAN_W-1:0] span_q, span_d;
  logic [ERR_W-1:0]  err_q, err_d;
  logic [SPAN_W-1:0] ofs_q, ofs_d;

  assign diff      = DIFF_W'(to_i) - DIFF_W'(from_i);
  assign diff_mag  = diff[DIFF_W-1] ? SPAN_W'(-diff) : SPAN_W'(diff);
  assign settled_o = err_q < {1'b0, span_q};

  // Error term compared against the tick count: one quotient step per cycle.
  always_comb begin
    base_d = base_q;
    mag_d  = mag_q;
    neg_d  = neg_q;
    span_d = span_q;
    err_d  = err_q;
    ofs_d  = ofs_q;
    if (load_i) begin
      base_d = from_i;
      mag_d  = diff_mag;
      neg_d  = diff[DIFF_W-1];
      span_d = span_i;
      err_d  = '0;
      ofs_d  = '0;
    end else if (step_i) begin
      err_d = err_q + {1'b0, mag_q};
    end else if (!settled_o) begin
      err_d = err_q - {1'b0, span_q};
      ofs_d = ofs_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mag_q  <= '0;
      neg_q  <= 1'b0;
      span_q <= SPAN_W'(1);
      err_q  <= '0;
      ofs_q  <= '0;
    end else begin
      base_q <= base_d;
      mag_q  <= mag_d;
      neg_q  <= neg_d;
      span_q <= span_d;
      err_q  <= err_d;
      ofs_q  <= ofs_d;
    end
  end

  assign level_o = neg_q ? base_q - level_t'({1'b0, ofs_q})
                         : base_q + level_t'({1'b0, ofs_q});

  // R4: the ramp never passes its end level
  p_offset_within_delta_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_q <= mag_q) else $error("ramp overshoot");

  // R4: ticks must not arrive while the interpolator is still settling
  p_step_after_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> settled_o) else $error("tick during settle");

endmodule

// File: rtl/haptic_wave_player.sv
module haptic_wave_player
  import hwp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  length_i,
  input  logic              bidir_i,
  input  logic              tick_i,
  output logic              ram_rd_en_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [7:0]        ram_data_i,
  output logic [7:0]        amp_o,
  output logic              amp_valid_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int TIME_W = 8;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic              start_go, take, drained;
  logic              rec_vld;
  logic [7:0]        rec_volt;
  logic [TIME_W-1:0] rec_time;
  level_t            rec_lvl;
  logic              rload, rstep, ramp_settled;
  level_t            r_from, r_to, ramp_lvl;
  logic [TIME_W-1:0] r_span;
  logic              seg_end, want_rec;

  seg_state_t        st_q, st_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [TIME_W-1:0] left_q, left_d;
  level_t            from_q, from_d;
  level_t            amp_q, amp_d;

  assign start_go = start_i && !busy_q;

  hwp_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_sn),
    .load_i     (start_go),
    .base_i     (start_addr_i),
    .len_i      (length_i),
    .take_i     (take),
    .rd_en_o    (ram_rd_en_o),
    .rd_addr_o  (ram_addr_o),
    .rd_data_i  (ram_data_i),
    .rec_vld_o  (rec_vld),
    .rec_volt_o (rec_volt),
    .rec_time_o (rec_time),
    .drained_o  (drained)
  );

  hwp_ramp #(.SPAN_W(TIME_W)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_sn),
    .load_i    (rload),
    .from_i    (r_from),
    .to_i      (r_to),
    .span_i    (r_span),
    .step_i    (rstep),
    .level_o   (ramp_lvl),
    .settled_o (ramp_settled)
  );

  assign rec_lvl  = decode_level(rec_volt[6:0], bidir_i);
  assign seg_end  = (st_q == SG_RUN) && tick_i && (left_q == TIME_W'(1));
  assign want_rec = (st_q == SG_EMPTY) || seg_end;

  always_comb begin
    busy_d = busy_q;
    st_d   = st_q;
    left_d = left_q;
    from_d = from_q;
    amp_d  = amp_q;
    done_d = 1'b0;
    take   = 1'b0;
    rload  = 1'b0;
    rstep  = 1'b0;
    r_from = from_q;
    r_to   = from_q;
    r_span = left_q;
    if (start_go) begin
      busy_d = 1'b1;
      st_d   = SG_EMPTY;
      amp_d  = '0;
    end else if (busy_q) begin
      if (want_rec) begin
        if (rec_vld) begin
          take = 1'b1;
          if (rec_time == '0) begin
            st_d = SG_EMPTY;
          end else begin
            from_d = rec_lvl;
            left_d = rec_time;
            amp_d  = rec_lvl;
            if (rec_volt[7]) begin
              st_d = SG_SETUP;
            end else begin
              rload  = 1'b1;
              r_from = rec_lvl;
              r_to   = rec_lvl;
              r_span = rec_time;
              st_d   = SG_RUN;
            end
          end
        end else if (drained) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          amp_d  = '0;
          st_d   = SG_EMPTY;
        end else begin
          st_d = SG_EMPTY;
        end
      end else if (st_q == SG_SETUP) begin
        if (rec_vld) begin
          rload = 1'b1;
          r_to  = rec_lvl;
          st_d  = SG_RUN;
        end else if (drained) begin
          rload = 1'b1;
          st_d  = SG_RUN;
        end
      end else if (st_q == SG_RUN) begin
        if (tick_i) begin
          left_d = left_q - 1'b1;
          rstep  = 1'b1;
        end else if (ramp_settled) begin
          amp_d = ramp_lvl;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= SG_EMPTY;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      left_q <= '0;
      from_q <= '0;
      amp_q  <= '0;
    end else begin
      st_q   <= st_d;
      busy_q <= busy_d;
      done_q <= done_d;
      left_q <= left_d;
      from_q <= from_d;
      amp_q  <= amp_d;
    end
  end

  assign amp_o       = amp_q[7:0];
  assign amp_valid_o = busy_q && (st_q != SG_EMPTY);
  assign busy_o      = busy_q;
  assign done_o      = done_q;

  // R8: no level is driven outside a playback
  p_idle_silent_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy_q |-> (amp_q == '0)) else $error("level while idle");

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    done_q |=> !done_q) else $error("done longer than one cycle");

  // R8: done comes with the end of busy
  p_done_clears_busy_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    done_q |-> !busy_q) else $error("done while busy");

  // R9: a start during playback does not end or restart it
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_q && start_i) |=> (busy_q || done_q)) else $error("start disturbed playback");

endmodule

// File: tb/haptic_wave_player_test.sv
module haptic_wave_player_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] saddr;
  logic [8:0] slen;
  logic       bidir;
  logic       tick;
  logic       rd_en;
  logic [7:0] raddr;
  logic [7:0] rdata;
  logic [7:0] amp;
  logic       valid, busy, done;

  int vectors = 0;
  int miscompares = 0;
  int done_cnt = 0;
  int win_lo = 0;
  int win_hi = -1;
  logic [7:0] mem [256];

  always #10 clk = ~clk;

  haptic_wave_player uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(saddr),
    .length_i(slen), .bidir_i(bidir), .tick_i(tick),
    .ram_rd_en_o(rd_en), .ram_addr_o(raddr), .ram_data_i(rdata),
    .amp_o(amp), .amp_valid_o(valid), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) if (rd_en) rdata <= mem[raddr];

  always @(posedge clk) if (rst_n && done) done_cnt++;

  // R11: every read stays inside the programmed window
  always @(posedge clk) begin
    if (rst_n && rd_en) begin
      vectors++;
      if (int'(raddr) < win_lo || int'(raddr) > win_hi) begin
        miscompares++;
        $display("FAIL R11 read address actual=%0d expected=%0d..%0d", raddr, win_lo, win_hi);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lvl(input logic [7:0] v, input bit bi);
    int c = int'(v[6:0]);
    if (!bi) return c;
    if (c >= 64) c -= 128;
    if (c == -64) c = -63;
    return c;
  endfunction

  task automatic run_case(input string req, input int base, input int len,
                          input bit bi, input bit poke);
    int exp_q[$];
    int n = len / 2;
    for (int i = 0; i < n; i++) begin
      logic [7:0] v = mem[base + 2*i];
      int t = int'(mem[base + 2*i + 1]);
      int a = lvl(v, bi);
      if (t == 0) continue;
      if (v[7] && i < n - 1) begin
        int b = lvl(mem[base + 2*i + 2], bi);
        int d = b - a;
        for (int j = 0; j < t; j++)
          exp_q.push_back(d < 0 ? a - ((-d) * j) / t : a + (d * j) / t);
      end else begin
        for (int j = 0; j < t; j++) exp_q.push_back(a);
      end
    end
    win_lo = base;
    win_hi = base + 2*n - 1;
    done_cnt = 0;
    @(negedge clk);
    start = 1'b1; saddr = 8'(base); slen = 9'(len); bidir = bi;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= exp_q.size(); k++) begin
      if (poke && k == 1) begin
        repeat (80) @(negedge clk);
        start = 1'b1; saddr = 8'd200; slen = 9'd10;
        @(negedge clk);
        start = 1'b0;
        repeat (109) @(negedge clk);
      end else begin
        repeat (190) @(negedge clk);
      end
      if (k < exp_q.size()) begin
        chk(req, $sformatf("amp interval %0d", k), int'($signed(amp)), exp_q[k]);
        chk(req, "valid", int'(valid), 1);
        chk(req, "busy", int'(busy), 1);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
      end else begin
        chk("R8", {req, " end amp"}, int'($signed(amp)), 0);
        chk("R8", {req, " end busy"}, int'(busy), 0);
        chk("R8", {req, " end valid"}, int'(valid), 0);
        chk("R8", {req, " done pulses"}, done_cnt, 1);
      end
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    // R1 R2 R3: holds, unsigned
    mem[0] = 8'h0A; mem[1] = 8'd3; mem[2] = 8'h64; mem[3] = 8'd2; mem[4] = 8'h7F; mem[5] = 8'd1;
    // R4 R5: ramp up then chained ramp down, then hold
    mem[16] = 8'h80; mem[17] = 8'd4; mem[18] = 8'hE4; mem[19] = 8'd3; mem[20] = 8'h14; mem[21] = 8'd2;
    // R2 R4: signed ramp -10 -> 40, hold 40, code -64 shown as -63
    mem[32] = 8'hF6; mem[33] = 8'd5; mem[34] = 8'h28; mem[35] = 8'd1; mem[36] = 8'h40; mem[37] = 8'd2;
    // R7 R6 R8: zero-length record, trailing ramp, stray odd byte
    mem[48] = 8'h32; mem[49] = 8'd0; mem[50] = 8'h9E; mem[51] = 8'd2; mem[52] = 8'h55;
    // R4: shallow ramp, steep ramp
    mem[80] = 8'h87; mem[81] = 8'd5; mem[82] = 8'h08; mem[83] = 8'd1;
    mem[84] = 8'h80; mem[85] = 8'd2; mem[86] = 8'h7F; mem[87] = 8'd1;
    // R7: ramp ending on a zero-length record
    mem[96] = 8'h8A; mem[97] = 8'd2; mem[98] = 8'h1E; mem[99] = 8'd0; mem[100] = 8'h05; mem[101] = 8'd1;

    rst_n = 1'b0; start = 1'b0; saddr = '0; slen = '0; bidir = 1'b0; tick = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10", "reset amp", int'(amp), 0);
    chk("R10", "reset busy", int'(busy), 0);
    chk("R10", "reset valid", int'(valid), 0);
    chk("R10", "reset done", int'(done), 0);
    chk("R10", "reset rd_en", int'(rd_en), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10", "post-reset busy", int'(busy), 0);

    run_case("R3", 0, 6, 1'b0, 1'b0);
    run_case("R5", 16, 6, 1'b0, 1'b0);
    run_case("R2", 32, 6, 1'b1, 1'b0);
    run_case("R6", 48, 5, 1'b0, 1'b0);
    run_case("R8", 64, 0, 1'b0, 1'b0);
    run_case("R9", 0, 6, 1'b0, 1'b1);
    run_case("R4", 80, 8, 1'b0, 1'b0);
    run_case("R7", 96, 6, 1'b0, 1'b0);
    run_case("R1", 0, 3, 1'b1, 1'b0);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule